// File: doc/BRIEF.md
# General-Purpose I/O Port with Change Interrupt

This block is one eight-bit bidirectional port of a small microcontroller. It sits on a simple register bus. It keeps a direction mask and an output latch, and from them it drives tri-state pad controls: an output value and an active-high output enable. It also drives an enable for a weak pull-up on each pad. Pad levels are brought into the clock domain through a synchroniser chain. Software reads the synchronised levels through the data register.

The upper half of the port watches for level changes. It does not compare each input with its value one clock earlier. Instead it compares each input with a snapshot that is refreshed whenever software reads or writes the data register. Any difference on an upper pin that is configured as an input sets a sticky change flag. The flag keeps being set for as long as the difference lasts. This means the normal service routine must first access the data register and only then clear the flag. An enable bit decides whether the flag reaches the interrupt output.

Top module: `gpio_port_ioc`

## Requirements
- R1: Direction bit 1 means the pin is an input, and `pad_oe_o` for that bit is 0. Direction bit 0 drives `pad_oe_o` high and places the output latch bit on `pad_out_o`. A write to register 0 loads the output latch.
- R2: `pull_en_o[i]` is 1 exactly when the control register bit 7 (pull-up disable, active high) is 0 and direction bit i is 1. A pin configured as an output never has its pull-up on.
- R3: After reset, the output latch is 0, every direction bit is 1, the pull-up disable bit is 1, the interrupt enable is 0, the change flag is 0 and `bus_rdata` is 0.
- R4: A read of register 0 returns the pad levels after two synchroniser stages. A pad change made just after clock edge k first appears in read data captured at edge k+3. Read data is registered, appears after the read edge, and holds until the next read.
- R5: Only bits 7:4 take part in change detection. A change on bits 3:0, or on an upper bit whose direction is output, never sets the flag.
- R6: Each upper input bit is compared with the snapshot taken at the most recent read or write of register 0. Any mismatch sets the change flag on the next edge. The flag stays set after the mismatch goes away.
- R7: Writing register 3 with bit 0 = 0 clears the flag, unless a mismatch is present in that cycle. Set wins over clear. Writing bit 0 = 1 has no effect.
- R8: `irq_o` equals the flag ANDed with control bit 0 (interrupt enable). The flag still records changes while the enable is 0.
- R9: During reset the snapshot loads the current synchronised levels. Pads that are held steady through reset therefore raise no flag afterwards.
- R10: Register 1 reads back the direction mask. Register 2 reads back bit 7 = pull-up disable and bit 0 = interrupt enable, with all other bits 0. Register 3 reads back the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 control, 3 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_i | input | 8 | Pad input levels (asynchronous) |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, active high |
| pull_en_o | output | 8 | Weak pull-up enables |
| irq_o | output | 1 | Change interrupt |

## Verification
The assertions assume that a read strobe and a write strobe are never raised together. They also assume that pad levels stay unchanged through reset for at least the depth of the synchroniser, since the no-spurious-flag check after reset depends on a settled snapshot. The bench keeps the two strobes exclusive in both its directed and random phases. It also holds the pads constant from time zero until well after reset is released, and changes pads only at the start of a clock period. Each clear-versus-set race and each revert-before-read case is driven from a known snapshot, so that the per-cycle reference model can resolve it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    stage[0] <= d;
    for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] sync_in,
  input  logic         flag,
  output logic [W-1:0] out_lat,
  output logic [W-1:0] dir,
  output logic         pu_dis,
  output logic         ien,
  output logic         port_acc,
  output logic         flag_clr,
  output logic [W-1:0] rd_data
);
  localparam int PU_BIT  = W - 1;
  localparam int IEN_BIT = 0;

  reg_sel_e     sel;
  logic [W-1:0] ctrl_view;
  logic [W-1:0] flag_view;

  assign sel      = reg_sel_e'(addr);
  assign port_acc = (wr_en | rd_en) && (sel == SEL_DATA);
  assign flag_clr = wr_en && (sel == SEL_FLAG) && !wr_data[0];

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[PU_BIT]  = pu_dis;
    ctrl_view[IEN_BIT] = ien;
    flag_view          = '0;
    flag_view[0]       = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_lat <= '0;
      dir     <= '1;
      pu_dis  <= 1'b1;
      ien     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          SEL_DATA: out_lat <= wr_data;
          SEL_DIR:  dir     <= wr_data;
          SEL_CTRL: begin
            pu_dis <= wr_data[PU_BIT];
            ien    <= wr_data[IEN_BIT];
          end
          default: ;
        endcase
      end
      if (rd_en) begin
        unique case (sel)
          SEL_DATA: rd_data <= sync_in;
          SEL_DIR:  rd_data <= dir;
          SEL_CTRL: rd_data <= ctrl_view;
          default:  rd_data <= flag_view;
        endcase
      end
    end
  end

  AST_DIR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir == '1 && !pu_dis == 1'b0)) else $error("dir reset"); // R3
endmodule

// File: rtl/gpio_change.sv
module gpio_change #(
  parameter int W  = 8,
  parameter int LO = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-LO-1:0]   sync_hi,
  input  logic [W-LO-1:0]   dir_hi,
  input  logic              port_acc,
  input  logic              flag_clr,
  output logic              flag
);
  localparam int CW = W - LO;

  logic [CW-1:0] snap;
  logic [CW-1:0] diff;
  logic          mism;

  generate
    for (genvar b = 0; b < CW; b++) begin : g_cmp
      assign diff[b] = dir_hi[b] & (sync_hi[b] ^ snap[b]);
    end
  endgenerate

  assign mism = |diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= sync_hi;
      flag <= 1'b0;
    end else begin
      if (port_acc) snap <= sync_hi;
      if (mism)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  AST_MISM_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    mism |=> flag) else $error("mismatch lost"); // R6
  AST_CLEAR_NEEDS_CALM: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> ($past(flag_clr) && !$past(mism))) else $error("bad clear"); // R7
  AST_SNAP_REFRESH: assert property (@(posedge clk) disable iff (rst)
    port_acc |=> (snap == $past(sync_hi))) else $error("snap stale"); // R6
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $stable(sync_hi)) |-> !mism) else $error("spurious"); // R9
endmodule

// File: rtl/gpio_port_ioc.sv
module gpio_port_ioc #(
  parameter int W           = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pull_en_o,
  output logic         irq_o
);
  logic [W-1:0] sync_q;
  logic [W-1:0] out_lat;
  logic [W-1:0] dir;
  logic         pu_dis;
  logic         ien;
  logic         port_acc;
  logic         flag_clr;
  logic         flag;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_i),
    .q   (sync_q)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .wr_data  (bus_wdata),
    .sync_in  (sync_q),
    .flag     (flag),
    .out_lat  (out_lat),
    .dir      (dir),
    .pu_dis   (pu_dis),
    .ien      (ien),
    .port_acc (port_acc),
    .flag_clr (flag_clr),
    .rd_data  (bus_rdata)
  );

  gpio_change #(.W(W), .LO(CHG_LO)) u_chg (
    .clk      (clk),
    .rst      (rst),
    .sync_hi  (sync_q[W-1:CHG_LO]),
    .dir_hi   (dir[W-1:CHG_LO]),
    .port_acc (port_acc),
    .flag_clr (flag_clr),
    .flag     (flag)
  );

  assign pad_out_o = out_lat;
  assign pad_oe_o  = ~dir;
  assign irq_o     = flag & ien;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pull
      assign pull_en_o[i] = dir[i] & ~pu_dis;
    end
  endgenerate

  AST_PULL_ONLY_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (pull_en_o & pad_oe_o) == '0) else $error("pull on output"); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag) else $error("irq without flag"); // R8
  AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe_o == '0 && pad_out_o == '0)) else $error("oe reset"); // R3
endmodule

// File: tb/gpio_port_ioc_test.sv
`timescale 1ns/1ps
module gpio_port_ioc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] pin_i = 8'hA5;
  logic [7:0] bus_rdata, pad_out_o, pad_oe_o, pull_en_o;
  logic       irq_o;

  int vectors = 0;
  int miscompares = 0;

  gpio_port_ioc uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pull_en_o(pull_en_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  logic [7:0] pin_hist [$];
  logic [7:0] m_lat, m_dir, m_rd, sb, n_rd;
  logic [3:0] m_snap;
  bit         m_pud, m_ien, m_flag, mm, clr, n_flag;

  always @(posedge clk) begin
    sb = (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 8'h00;
    pin_hist.push_back(pin_i);
    if (pin_hist.size() > 4) void'(pin_hist.pop_front());
    if (rst) begin
      m_lat = 8'h00; m_dir = 8'hFF; m_pud = 1'b1; m_ien = 1'b0;
      m_flag = 1'b0; m_rd = 8'h00; m_snap = sb[7:4];
    end else begin
      mm = ((sb[7:4] ^ m_snap) & m_dir[7:4]) != 4'h0;
      n_rd = m_rd;
      if (bus_rd) begin
        case (bus_addr)
          2'd0: n_rd = sb;
          2'd1: n_rd = m_dir;
          2'd2: n_rd = {m_pud, 6'b0, m_ien};
          default: n_rd = {7'b0, m_flag};
        endcase
      end
      clr = bus_wr && bus_addr == 2'd3 && !bus_wdata[0];
      n_flag = mm ? 1'b1 : (clr ? 1'b0 : m_flag);
      if ((bus_wr || bus_rd) && bus_addr == 2'd0) m_snap = sb[7:4];
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_lat = bus_wdata;
          2'd1: m_dir = bus_wdata;
          2'd2: begin m_pud = bus_wdata[7]; m_ien = bus_wdata[0]; end
          default: ;
        endcase
      end
      m_rd = n_rd;
      m_flag = n_flag;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    chk(pad_out_o == m_lat, "R1 pad_out", pad_out_o, m_lat);
    chk(pad_oe_o == ~m_dir, "R1 pad_oe", pad_oe_o, ~m_dir);
    chk(pull_en_o == (m_pud ? 8'h00 : m_dir), "R2 pull_en", pull_en_o, m_pud ? 8'h00 : m_dir);
    chk(irq_o == (m_flag & m_ien), "R8 irq", {7'b0, irq_o}, {7'b0, m_flag & m_ien});
    chk(bus_rdata == m_rd, "R10 rdata", bus_rdata, m_rd);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    step();
    chk(pad_oe_o == 8'h00, "R3 oe reset", pad_oe_o, 8'h00);
    chk(pull_en_o == 8'h00, "R3 pull reset", pull_en_o, 8'h00);
    chk(bus_rdata == 8'h00, "R3 rdata reset", bus_rdata, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R9 no flag after reset", v, 8'h00);
    rd(2'd2, v); chk(v == 8'h80, "R10 ctrl reset", v, 8'h80);
    rd(2'd1, v); chk(v == 8'hFF, "R10 dir reset", v, 8'hFF);
    rd(2'd0, v); chk(v == 8'hA5, "R4 port read", v, 8'hA5);

    // synchroniser latency
    pin_i = 8'h5A;
    rd(2'd0, v); chk(v == 8'hA5, "R4 latency e1", v, 8'hA5);
    rd(2'd0, v); chk(v == 8'hA5, "R4 latency e2", v, 8'hA5);
    rd(2'd0, v); chk(v == 8'h5A, "R4 latency e3", v, 8'h5A);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R7 clear after read", v, 8'h00);

    // pull-ups and direction
    wr(2'd2, 8'h01);
    chk(pull_en_o == 8'hFF, "R2 pull all inputs", pull_en_o, 8'hFF);
    wr(2'd1, 8'h0F);
    chk(pull_en_o == 8'h0F, "R2 pull off outputs", pull_en_o, 8'h0F);
    wr(2'd0, 8'h3C);
    chk(pad_out_o == 8'h3C && pad_oe_o == 8'hF0, "R1 drive", pad_out_o, 8'h3C);

    // lower bits and output bits excluded
    pin_i = 8'hA5;
    idle(4);
    rd(2'd3, v); chk(v == 8'h00, "R5 excluded bits", v, 8'h00);
    rd(2'd0, v);
    wr(2'd1, 8'hFF);
    idle(2);
    rd(2'd3, v); chk(v == 8'h00, "R6 snapshot matches", v, 8'h00);

    // change on bit 5
    pin_i = 8'h85;
    idle(4);
    chk(irq_o == 1'b1, "R6 change raises irq", {7'b0, irq_o}, 8'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 8'h01, "R7 clear blocked by mismatch", v, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd0, v);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R7 clear after refresh", v, 8'h00);

    // change then revert: flag stays sticky
    pin_i = 8'hA5; idle(3);
    pin_i = 8'h85; idle(4);
    rd(2'd3, v); chk(v == 8'h01, "R6 sticky after revert", v, 8'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R7 clear once calm", v, 8'h00);

    // interrupt gated off still records
    wr(2'd2, 8'h00);
    pin_i = 8'h05; idle(4);
    chk(irq_o == 1'b0, "R8 irq gated", {7'b0, irq_o}, 8'h00);
    rd(2'd3, v); chk(v == 8'h01, "R8 flag recorded", v, 8'h01);
    rd(2'd0, v); wr(2'd3, 8'h00);

    // set beats clear
    pin_i = 8'h15;
    for (int i = 0; i < 6; i++) wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 8'h01, "R7 set wins", v, 8'h01);
    rd(2'd0, v); wr(2'd3, 8'h00);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 5) == 0) pin_i = 8'($urandom);
      bus_addr = 2'($urandom);
      bus_wdata = 8'($urandom);
      bus_wr = (op < 3);
      bus_rd = (op >= 3 && op < 6);
      step();
      bus_wr = 1'b0; bus_rd = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule